// File: doc/BRIEF.md
# Banked Strided Vector Load Unit

This block fetches one vector of words from an interleaved memory. A start pulse brings in a base word address, a signed stride and an element count. The unit then walks the addresses base, base+stride, base+2·stride and so on. Each address goes to the bank given by its low bits. A bank that was accessed recently stays busy for a fixed number of cycles, and an element that targets a busy bank waits there. Every later element waits behind it, so element order is kept at all times.

Returned words pass through a fixed memory latency and are presented in element order on a valid/ready write port, which feeds a vector register file. A word is transferred on a cycle where valid and ready are both high. While valid is high and ready is low, the port holds its index and data unchanged. Back-pressure never drops an element. It only delays the write port, and through it the end of the load. A busy flag, a one-cycle done pulse and a cycle counter report how long the load took. The stride decides how often banks collide, and so it decides that duration.

Top module: `vld_bank_engine`

## Requirements
- R1: Element i reads the word at address (base + i·stride) mod 2^ADDR_W, with the stride taken as a two's-complement ADDR_W-bit value. The memory word at address A holds {A[15:0] XOR 16'hC3A5, A[15:0]}.
- R2: The bank of an address is its value mod NUM_BANKS, given by its low log2(NUM_BANKS) bits. The row inside that bank is the remaining upper bits.
- R3: After a bank is accessed in cycle k, it accepts no further access before cycle k+BANK_BUSY.
- R4: Elements appear on the write port strictly in index order 0..L-1. An element waiting on a busy bank holds back all elements after it.
- R5: The first element is issued in the cycle after start is accepted. An element issued in cycle k appears on the write port in cycle k+MEM_LAT. When no bank conflicts occur, one element is issued per clock.
- R6: With defaults (8 banks, busy 6, latency 12) and ready held high, a 64-element load with stride 1 reports 76 cycles. The same load with stride 32 reports 12+1+6·63 = 391 cycles.
- R7: While wr_valid_o is high and wr_ready_i is low, wr_valid_o, wr_idx_o and wr_data_o keep their values into the next cycle.
- R8: done_o is high for exactly one cycle: the cycle after the last element's handshake. busy_o falls at the same edge.
- R9: A start is ignored while busy_o is high, and also when len_i is 0. A length above MAX_VL is treated as MAX_VL.
- R10: cyc_count_o is 1 in the first busy cycle. It rises by one each further busy cycle up to and including the last handshake, and then holds until the next accepted start.
- R11: After reset, busy_o, done_o and wr_valid_o are 0, cyc_count_o is 0 and all banks are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| base_i | input | ADDR_W | Word address of element 0 |
| stride_i | input | ADDR_W | Signed word stride between elements |
| len_i | input | $clog2(MAX_VL+1) | Element count |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | One-cycle pulse after the last element is written |
| cyc_count_o | output | CNT_W | Cycles taken by the current or last load |
| wr_valid_o | output | 1 | Write port holds an element |
| wr_ready_i | input | 1 | Register file accepts the element |
| wr_idx_o | output | $clog2(MAX_VL) | Element index being written |
| wr_data_o | output | 32 | Element data |

## Verification
Element 0 is issued in the cycle right after the start edge. Any element issued in cycle k must appear on the write port exactly MEM_LAT cycles later, or later still if the port is stalled. done_o and the final count are due one edge after the last handshake. The reference model keeps a per-bank "free from" cycle and a queue of returns, each stamped with the cycle in which it becomes visible. It advances at each rising edge from the same inputs the design sees. Its predictions are compared against the outputs at the falling edge of every cycle, so each result is checked in exactly the cycle it is due and never one edge early or late.

// File: rtl/vld_pkg.sv
package vld_pkg;

  typedef logic [31:0] vld_word_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vld_state_e;

  // Fixed content of the modelled memory: a function of the word address.
  function automatic vld_word_t vld_fill(input logic [15:0] a);
    return {a ^ 16'hC3A5, a};
  endfunction

endpackage

// File: rtl/vld_addr_gen.sv
module vld_addr_gen #(
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 7,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              adv_i,
  output logic              pend_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IDX_W-1:0]  idx_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] stride_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LEN_W-1:0]  rem_q;

  // Running sum replaces the multiply: addr(i+1) = addr(i) + stride, mod 2^ADDR_W.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stride_q <= '0;
      idx_q    <= '0;
      rem_q    <= '0;
    end else if (load_i) begin
      addr_q   <= base_i;
      stride_q <= stride_i;
      idx_q    <= '0;
      rem_q    <= len_i;
    end else if (adv_i) begin
      addr_q   <= addr_q + stride_q;
      idx_q    <= idx_q + 1'b1;
      rem_q    <= rem_q - 1'b1;
    end
  end

  assign pend_o = (rem_q != '0);
  assign addr_o = addr_q;
  assign idx_o  = idx_q;

endmodule

// File: rtl/vld_bank.sv
module vld_bank
  import vld_pkg::*;
#(
  parameter int BANK_ID   = 0,
  parameter int NUM_BANKS = 8,
  parameter int ROWS      = 128,
  parameter int BUSY      = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_i,
  input  logic [$clog2(ROWS)-1:0] row_i,
  output logic                    busy_o,
  output vld_word_t               rd_data_o
);

  localparam int TW = (BUSY > 1) ? $clog2(BUSY) : 1;

  vld_word_t      mem_q [ROWS];
  logic [TW-1:0]  tmr_q;

  // Contents are loaded at reset and then only read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        mem_q[r] <= vld_fill(16'(r * NUM_BANKS + BANK_ID));
      end
    end
  end

  // Busy timer: an access in cycle k keeps the bank closed through cycle k+BUSY-1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (acc_i) begin
      tmr_q <= TW'(BUSY - 1);
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  assign busy_o    = (tmr_q != '0);
  assign rd_data_o = mem_q[row_i];

endmodule

// File: rtl/vld_ret_q.sv
module vld_ret_q
  import vld_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int LAT   = 12,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [IDX_W-1:0] idx_i,
  input  vld_word_t        data_i,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [IDX_W-1:0] idx_o,
  output vld_word_t        data_o
);

  localparam int NS = LAT - 1;          // latency stages before the FIFO
  localparam int PW = $clog2(DEPTH);

  logic [NS-1:0]    pv_q;
  logic [IDX_W-1:0] pidx_q [NS];
  vld_word_t        pdat_q [NS];

  logic [IDX_W-1:0] fidx_q [DEPTH];
  vld_word_t        fdat_q [DEPTH];
  logic [PW:0]      wp_q, rp_q;
  logic             wr_en, pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= '0;
    end else begin
      pv_q[0] <= push_i;
      for (int s = 1; s < NS; s++) pv_q[s] <= pv_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    pidx_q[0] <= idx_i;
    pdat_q[0] <= data_i;
    for (int s = 1; s < NS; s++) begin
      pidx_q[s] <= pidx_q[s-1];
      pdat_q[s] <= pdat_q[s-1];
    end
  end

  assign wr_en = pv_q[NS-1];
  assign pop   = valid_o && ready_i;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      fidx_q[wp_q[PW-1:0]] <= pidx_q[NS-1];
      fdat_q[wp_q[PW-1:0]] <= pdat_q[NS-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (wr_en) wp_q <= wp_q + 1'b1;
      if (pop)   rp_q <= rp_q + 1'b1;
    end
  end

  assign valid_o = (wp_q != rp_q);
  assign idx_o   = fidx_q[rp_q[PW-1:0]];
  assign data_o  = fdat_q[rp_q[PW-1:0]];

endmodule

// File: rtl/vld_bank_engine.sv
module vld_bank_engine
  import vld_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_BUSY = 6,
  parameter int MEM_LAT   = 12,
  parameter int ADDR_W    = 10,
  parameter int MAX_VL    = 64,
  parameter int CNT_W     = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [ADDR_W-1:0]             base_i,
  input  logic [ADDR_W-1:0]             stride_i,
  input  logic [$clog2(MAX_VL+1)-1:0]   len_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [CNT_W-1:0]              cyc_count_o,
  output logic                          wr_valid_o,
  input  logic                          wr_ready_i,
  output logic [$clog2(MAX_VL)-1:0]     wr_idx_o,
  output logic [31:0]                   wr_data_o
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROWS   = (2 ** ADDR_W) / NUM_BANKS;
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int LEN_W  = $clog2(MAX_VL + 1);
  localparam int IDX_W  = $clog2(MAX_VL);

  vld_state_e        st_q;
  logic [LEN_W-1:0]  len_q, len_eff;
  logic              start_ok, issue, finish, hs;
  logic              ag_pend;
  logic [ADDR_W-1:0] ag_addr;
  logic [IDX_W-1:0]  ag_idx;
  logic [BANK_W-1:0] bank_sel;
  logic [ROW_W-1:0]  bank_row;
  logic [NUM_BANKS-1:0] bank_busy;
  vld_word_t         bank_rd [NUM_BANKS];
  vld_word_t         sel_rd;
  logic              done_q;
  logic [CNT_W-1:0]  cnt_q;

  assign len_eff  = (len_i > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : len_i;
  assign start_ok = (st_q == ST_IDLE) && start_i && (len_i != '0);

  vld_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) agen_i (
    .clk(clk), .rst_n(rst_n), .load_i(start_ok), .base_i(base_i),
    .stride_i(stride_i), .len_i(len_eff), .adv_i(issue),
    .pend_o(ag_pend), .addr_o(ag_addr), .idx_o(ag_idx)
  );

  assign bank_sel = ag_addr[BANK_W-1:0];
  assign bank_row = ag_addr[ADDR_W-1:BANK_W];

  // One issue per cycle at most, and only when the head element's bank is free.
  assign issue = (st_q == ST_RUN) && ag_pend && !bank_busy[bank_sel];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    vld_bank #(.BANK_ID(g), .NUM_BANKS(NUM_BANKS), .ROWS(ROWS), .BUSY(BANK_BUSY)) bank_i (
      .clk(clk), .rst_n(rst_n),
      .acc_i(issue && (bank_sel == BANK_W'(g))),
      .row_i(bank_row),
      .busy_o(bank_busy[g]),
      .rd_data_o(bank_rd[g])
    );
  end

  assign sel_rd = bank_rd[bank_sel];

  vld_ret_q #(.IDX_W(IDX_W), .LAT(MEM_LAT), .DEPTH(MAX_VL)) retq_i (
    .clk(clk), .rst_n(rst_n), .push_i(issue), .idx_i(ag_idx), .data_i(sel_rd),
    .valid_o(wr_valid_o), .ready_i(wr_ready_i), .idx_o(wr_idx_o), .data_o(wr_data_o)
  );

  assign hs     = wr_valid_o && wr_ready_i;
  assign finish = hs && (wr_idx_o == IDX_W'(len_q - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      len_q  <= '0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= finish;
      if (start_ok) begin
        st_q  <= ST_RUN;
        len_q <= len_eff;
        cnt_q <= CNT_W'(1);
      end else if (st_q == ST_RUN) begin
        if (finish) begin
          st_q <= ST_IDLE;
        end else if (cnt_q != '1) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o      = (st_q == ST_RUN);
  assign done_o      = done_q;
  assign cyc_count_o = cnt_q;

endmodule

// File: rtl/vld_bank_engine_chk.sv
module vld_bank_engine_chk #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_BUSY = 6,
  parameter int MAX_VL    = 64,
  parameter int CNT_W     = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        busy_o,
  input logic                        done_o,
  input logic [CNT_W-1:0]            cyc_count_o,
  input logic                        wr_valid_o,
  input logic                        wr_ready_i,
  input logic [$clog2(MAX_VL)-1:0]   wr_idx_o,
  input logic [31:0]                 wr_data_o,
  input logic                        issue,
  input logic [$clog2(NUM_BANKS)-1:0] bank_sel
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int IDX_W  = $clog2(MAX_VL);
  localparam int GW     = $clog2(BANK_BUSY + 1);

  logic [IDX_W-1:0] exp_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       exp_idx_q <= '0;
    else if (!busy_o)                 exp_idx_q <= '0;
    else if (wr_valid_o && wr_ready_i) exp_idx_q <= exp_idx_q + 1'b1;
  end

  // R4: write port carries elements in index order
  assert_in_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (wr_idx_o == exp_idx_q));

  assert_valid_inside_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> busy_o);

  // R7: stalled write port holds its content
  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_idx_o) && $stable(wr_data_o)));

  // R8: done is a single pulse coinciding with the end of busy
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_ends_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R10: counter steps by one through a load
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (cyc_count_o == CNT_W'($past(cyc_count_o) + 1'b1)));

  // R3: spacing between accesses to one bank, measured by a local counter
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gap
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   gap_q <= GW'(BANK_BUSY);
      else if (issue && (bank_sel == BANK_W'(b)))   gap_q <= GW'(1);
      else if (gap_q < GW'(BANK_BUSY))              gap_q <= gap_q + 1'b1;
    end
    assert_bank_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (bank_sel == BANK_W'(b))) |-> (gap_q >= GW'(BANK_BUSY)));
  end

endmodule

bind vld_bank_engine vld_bank_engine_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_BUSY(BANK_BUSY), .MAX_VL(MAX_VL), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .cyc_count_o(cyc_count_o), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
  .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .issue(issue), .bank_sel(bank_sel)
);

// File: tb/vld_bank_engine_tb_top.sv
`timescale 1ns/1ps
module vld_bank_engine_tb_top;

  localparam int NB    = 8;
  localparam int BUSY  = 6;
  localparam int LAT   = 12;
  localparam int AW    = 10;
  localparam int MVL   = 64;
  localparam int CW    = 16;
  localparam int LW    = $clog2(MVL + 1);
  localparam int IW    = $clog2(MVL);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic [AW-1:0] stride_i = '0;
  logic [LW-1:0] len_i = '0;
  logic          busy_o, done_o, wr_valid_o;
  logic          wr_ready_i = 1'b1;
  logic [CW-1:0] cyc_count_o;
  logic [IW-1:0] wr_idx_o;
  logic [31:0]   wr_data_o;

  always #4 clk = ~clk;   // 125 MHz

  vld_bank_engine #(.NUM_BANKS(NB), .BANK_BUSY(BUSY), .MEM_LAT(LAT), .ADDR_W(AW),
                    .MAX_VL(MVL), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .stride_i(stride_i),
    .len_i(len_i), .busy_o(busy_o), .done_o(done_o), .cyc_count_o(cyc_count_o),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_idx_o(wr_idx_o),
    .wr_data_o(wr_data_o)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mem_word(input int a);
    logic [15:0] w;
    w = 16'(a);
    return {w ^ 16'hC3A5, w};
  endfunction

  // ---------------- behavioural reference model ----------------
  int          cyc;
  int          free_at [NB];
  int          q_vis[$];
  int          q_idx[$];
  logic [31:0] q_dat[$];
  bit          m_busy, m_done;
  int          m_cnt, m_len, m_i, m_addr, m_stride;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; m_busy = 0; m_done = 0; m_cnt = 0; m_len = 0; m_i = 0;
      m_addr = 0; m_stride = 0;
      for (int b = 0; b < NB; b++) free_at[b] = 0;
      q_vis.delete(); q_idx.delete(); q_dat.delete();
    end else begin
      bit fin;
      fin = 0;
      if (q_vis.size() > 0 && q_vis[0] <= cyc && wr_ready_i) begin
        if (q_idx[0] == m_len - 1) fin = 1;
        void'(q_vis.pop_front()); void'(q_idx.pop_front()); void'(q_dat.pop_front());
      end
      if (m_busy && m_i < m_len) begin
        int b;
        b = m_addr % NB;
        if (free_at[b] <= cyc) begin
          q_vis.push_back(cyc + LAT);
          q_idx.push_back(m_i);
          q_dat.push_back(mem_word(m_addr));
          free_at[b] = cyc + BUSY;
          m_i++;
          m_addr = (m_addr + m_stride) & ((1 << AW) - 1);
        end
      end
      if (!m_busy && start_i && int'(len_i) != 0) begin
        m_busy = 1; m_cnt = 1; m_i = 0;
        m_len = (int'(len_i) > MVL) ? MVL : int'(len_i);
        m_addr = int'(base_i);
        m_stride = int'($signed(stride_i));
      end else if (m_busy) begin
        if (fin) m_busy = 0;
        else m_cnt++;
      end
      m_done = fin;
      cyc++;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit ev;
      ev = (q_vis.size() > 0) && (q_vis[0] <= cyc);
      check(busy_o == m_busy, "R8 busy", longint'(busy_o), longint'(m_busy));
      check(done_o == m_done, "R8 done", longint'(done_o), longint'(m_done));
      check(int'(cyc_count_o) == m_cnt, "R10 count", longint'(cyc_count_o), longint'(m_cnt));
      check(wr_valid_o == ev, "R3 R5 valid", longint'(wr_valid_o), longint'(ev));
      if (ev && wr_valid_o) begin
        check(int'(wr_idx_o) == q_idx[0], "R4 R7 index", longint'(wr_idx_o), longint'(q_idx[0]));
        check(wr_data_o == q_dat[0], "R1 R2 data", longint'(wr_data_o), longint'(q_dat[0]));
      end
    end
  end

  // ---------------- write-port back-pressure ----------------
  bit          bp_on = 0;
  logic [15:0] lf = 16'hACE1;
  always @(negedge clk) begin
    if (bp_on) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      wr_ready_i = lf[0] | lf[3];
    end else begin
      wr_ready_i = 1'b1;
    end
  end

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic run_load(input int base, input int stride, input int len,
                          input int exp_cnt, input string tag, input bit poke);
    @(negedge clk);
    start_i = 1'b1; base_i = AW'(base); stride_i = AW'(stride); len_i = LW'(len);
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      // R9: a start while busy must not disturb the running load
      repeat (5) @(negedge clk);
      start_i = 1'b1; base_i = AW'(7); stride_i = AW'(3); len_i = LW'(5);
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    if (exp_cnt >= 0)
      check(int'(cyc_count_o) == exp_cnt, tag, longint'(cyc_count_o), longint'(exp_cnt));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(busy_o == 1'b0, "R11 busy after reset", longint'(busy_o), 0);
    check(done_o == 1'b0, "R11 done after reset", longint'(done_o), 0);
    check(wr_valid_o == 1'b0, "R11 valid after reset", longint'(wr_valid_o), 0);
    check(cyc_count_o == '0, "R11 count after reset", longint'(cyc_count_o), 0);

    run_load(0, 1, 64, 76, "R6 stride 1 total cycles", 0);
    run_load(0, 32, 64, 391, "R6 stride 32 total cycles", 0);
    run_load(16, 2, 64, -1, "R3 stride 2", 0);
    run_load(5, 3, 40, -1, "R3 stride 3", 0);
    run_load(3, -1, 20, -1, "R1 negative stride wrap", 0);
    run_load(9, 0, 10, -1, "R3 stride 0", 0);
    run_load(100, 4, 16, -1, "R3 stride 4", 0);
    run_load(1000, 1, 1, 13, "R5 single element", 0);
    run_load(0, 1, 64, 76, "R9 start while busy ignored", 1);
    run_load(0, 1, 100, 76, "R9 length clamp", 0);

    // R9: zero length start is ignored
    @(negedge clk);
    start_i = 1'b1; base_i = AW'(4); stride_i = AW'(1); len_i = LW'(0);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b0, "R9 zero length ignored", longint'(busy_o), 0);
    repeat (2) @(negedge clk);

    // R7: back-pressure on the write port
    bp_on = 1;
    run_load(40, 1, 64, -1, "R7 stride 1 stalled", 0);
    run_load(77, 5, 48, -1, "R7 stride 5 stalled", 0);
    run_load(2, 6, 30, -1, "R7 stride 6 stalled", 0);
    bp_on = 0;
    repeat (4) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule